// File: doc/BRIEF.md
# Frame-Synchronized Serial Receiver

This block turns a serial data line into parallel words. A bit-clock enable marks the cycles on which the data line and the frame sync are sampled. An edge on the frame sync marks the start of a word. The block shifts the following bits into an assembly register and presents the finished word right-justified, with a valid strobe that lasts one clock.

Configuration inputs select the word length, whether the sync is one bit long or a full word long, whether the sync leads the data by one bit (early timing), the sync polarity, and whether bits arrive MSB first or LSB first. The receiver looks for a new sync edge only once the current frame may end. A sync edge that arrives too soon is treated as an error: the partial word is thrown away, a sticky flag is set, and the receiver waits for a later edge. Any number of idle bit slots may sit between frames.

Top module: `fsync_rx`

## Requirements
- R1: During and right after reset, rx_valid is 0, rej_flag is 0 and rx_word is all zeros.
- R2: With cfg_fs_low = 0 the sync is active high. A frame starts on the slot where fsync is sampled 1 and the previous sample was 0.
- R3: With cfg_fs_low = 1 the sync is active low and the frame aligns to the end of the low pulse. A frame starts on the slot where fsync is sampled 1 and the previous sample was 0. The slot where fsync goes low does not start a frame.
- R4: cfg_wlen selects the word length: 0 = 8 bits, 1 = 12 bits, 2 = 16 bits, 3 = 24 bits. The word appears in the low bits of rx_word, and the unused upper bits read 0.
- R5: With cfg_lsb_first = 0 the first bit received lands in the most significant bit of the word. With cfg_lsb_first = 1 it lands in bit 0.
- R6: In normal timing, the first data bit is sampled in the same slot as the sync edge. rx_valid is high for exactly the one clock that follows the slot of the last bit.
- R7: With cfg_word_fs = 1 and cfg_early = 1, the first data bit is sampled in the slot after the sync edge. A sync edge during the last bit of a frame is accepted, and the next frame follows with no gap.
- R8: With cfg_word_fs = 0 (one-bit sync), cfg_early has no effect, and normal timing applies.
- R9: A sync edge that comes while a frame is in progress is rejected. In normal timing this covers any slot up to and including the last bit. In early timing it covers any slot before the last bit. A rejected edge produces no word, sets rej_flag on the next clock, and does not start a frame. The next accepted edge starts a new frame.
- R10: rej_flag stays set until rej_clr is 1 on a clock edge. If a rejection happens on the same clock edge, the flag stays set.
- R11: fsync and sdata are sampled only on cycles where bit_en is 1. Idle slots between frames produce no words. rx_word changes only together with rx_valid.
- R12: Word length, bit order and early timing are captured when a frame starts. Changing them while the frame is running does not change that frame's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-slot enable; inputs are sampled when this is 1 |
| sdata | input | 1 | Serial data line |
| fsync | input | 1 | Frame sync line |
| cfg_wlen | input | 2 | Word length code (8/12/16/24) |
| cfg_word_fs | input | 1 | 1 = sync lasts a full word, 0 = sync lasts one bit |
| cfg_early | input | 1 | Early sync timing (applies only when cfg_word_fs = 1) |
| cfg_fs_low | input | 1 | Sync polarity, 1 = active low |
| cfg_lsb_first | input | 1 | Bit order, 1 = LSB first |
| rej_clr | input | 1 | Write-one-to-clear for rej_flag |
| rx_word | output | 24 | Received word, right-justified |
| rx_valid | output | 1 | One-clock strobe for a new word |
| rej_flag | output | 1 | Sticky flag for a rejected sync |

## Verification
The assertions check the cycle-level rules on every clock:
- the valid strobe lasts one clock and follows a sampled slot;
- the output word holds between strobes;
- a rejection always sets the flag and never yields a word;
- the flag falls only after a clear request.

Only the bench scenarios can show the rest: that words are correct for each length and bit order, that alignment follows each polarity and timing mode, that early sync is ignored in bit-sync mode, that back-to-back frames are accepted, and that settings captured at frame start hold while the inputs change.

// File: rtl/fsync_rx_pkg.sv
package fsync_rx_pkg;

    localparam int MAX_W = 24;
    localparam int CNT_W = $clog2(MAX_W);

    localparam int LEN_A = 8;
    localparam int LEN_B = 12;
    localparam int LEN_C = 16;
    localparam int LEN_D = 24;

    typedef logic [MAX_W-1:0] word_t;
    typedef logic [CNT_W-1:0] pos_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_RECV
    } rx_state_e;

    // Settings captured at the start of a frame
    typedef struct packed {
        pos_t last_pos;
        logic lsb_first;
        logic early;
    } frame_cfg_t;

    // Per-slot capture command from the controller to the assembler
    typedef struct packed {
        logic en;
        logic first;
        logic last;
        pos_t pos;
    } cap_t;

    function automatic pos_t wlen_last(input logic [1:0] code);
        case (code)
            2'd0:    return pos_t'(LEN_A - 1);
            2'd1:    return pos_t'(LEN_B - 1);
            2'd2:    return pos_t'(LEN_C - 1);
            default: return pos_t'(LEN_D - 1);
        endcase
    endfunction

    function automatic pos_t bit_slot(input frame_cfg_t c, input pos_t n);
        return c.lsb_first ? n : pos_t'(c.last_pos - n);
    endfunction

endpackage

// File: rtl/fsync_rx_edge.sv
module fsync_rx_edge (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic fsync,
    input  logic pol_low,
    output logic fs_edge
);
    logic act;
    logic prev_act;

    // Normalize to "active" level, then pick leading or trailing transition
    assign act = fsync ^ pol_low;

    always_comb begin
        if (pol_low)
            fs_edge = bit_en && prev_act && !act;
        else
            fs_edge = bit_en && !prev_act && act;
    end

    always_ff @(posedge clk) begin
        if (rst)
            prev_act <= 1'b0;
        else if (bit_en)
            prev_act <= act;
    end
endmodule

// File: rtl/fsync_rx_ctrl.sv
module fsync_rx_ctrl
    import fsync_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       fs_edge,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_word_fs,
    input  logic       cfg_early,
    input  logic       cfg_lsb_first,
    input  logic       rej_clr,
    output cap_t       cap,
    output logic       rej_pulse,
    output logic       rej_flag
);
    rx_state_e  state;
    pos_t       cnt;
    frame_cfg_t fr;
    frame_cfg_t fresh;
    frame_cfg_t use_cfg;
    logic       in_recv;
    logic       at_last;
    logic       start_now;
    logic       arm_cap;
    logic       rej;
    pos_t       n_pos;

    always_comb begin
        fresh.last_pos  = wlen_last(cfg_wlen);
        fresh.lsb_first = cfg_lsb_first;
        fresh.early     = cfg_word_fs & cfg_early;

        in_recv   = bit_en && (state == ST_RECV);
        at_last   = in_recv && (cnt == fr.last_pos);
        rej       = in_recv && fs_edge && !(at_last && fr.early);
        start_now = bit_en && (state == ST_IDLE) && fs_edge && !fresh.early;
        arm_cap   = bit_en && (state == ST_ARM);

        use_cfg   = start_now ? fresh : fr;
        n_pos     = (start_now || arm_cap) ? '0 : cnt;

        cap.en    = start_now || arm_cap || (in_recv && !rej);
        cap.first = start_now || arm_cap;
        cap.last  = at_last && !rej;
        cap.pos   = bit_slot(use_cfg, n_pos);
        rej_pulse = rej;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            fr       <= '0;
            rej_flag <= 1'b0;
        end else begin
            if (rej)
                rej_flag <= 1'b1;
            else if (rej_clr)
                rej_flag <= 1'b0;

            if (bit_en) begin
                unique case (state)
                    ST_IDLE: begin
                        if (fs_edge) begin
                            fr <= fresh;
                            if (fresh.early) begin
                                state <= ST_ARM;
                            end else begin
                                state <= ST_RECV;
                                cnt   <= pos_t'(1);
                            end
                        end
                    end
                    ST_ARM: begin
                        state <= ST_RECV;
                        cnt   <= pos_t'(1);
                    end
                    ST_RECV: begin
                        if (rej) begin
                            state <= ST_IDLE;
                        end else if (at_last) begin
                            if (fr.early && fs_edge) begin
                                fr    <= fresh;
                                state <= ST_ARM;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/fsync_rx_shift.sv
module fsync_rx_shift
    import fsync_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sdata,
    input  cap_t  cap,
    output word_t rx_word,
    output logic  rx_valid
);
    word_t acc;
    word_t nxt;

    always_comb begin
        nxt = cap.first ? '0 : acc;
        nxt[cap.pos] = sdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= cap.en && cap.last;
            if (cap.en)
                acc <= nxt;
            if (cap.en && cap.last)
                rx_word <= nxt;
        end
    end
endmodule

// File: rtl/fsync_rx.sv
module fsync_rx
    import fsync_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             sdata,
    input  logic             fsync,
    input  logic [1:0]       cfg_wlen,
    input  logic             cfg_word_fs,
    input  logic             cfg_early,
    input  logic             cfg_fs_low,
    input  logic             cfg_lsb_first,
    input  logic             rej_clr,
    output logic [MAX_W-1:0] rx_word,
    output logic             rx_valid,
    output logic             rej_flag
);
    logic fs_edge;
    logic rej_pulse;
    cap_t cap;

    fsync_rx_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .fsync   (fsync),
        .pol_low (cfg_fs_low),
        .fs_edge (fs_edge)
    );

    fsync_rx_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .fs_edge       (fs_edge),
        .cfg_wlen      (cfg_wlen),
        .cfg_word_fs   (cfg_word_fs),
        .cfg_early     (cfg_early),
        .cfg_lsb_first (cfg_lsb_first),
        .rej_clr       (rej_clr),
        .cap           (cap),
        .rej_pulse     (rej_pulse),
        .rej_flag      (rej_flag)
    );

    fsync_rx_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .sdata    (sdata),
        .cap      (cap),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );
endmodule

// File: rtl/fsync_rx_chk.sv
module fsync_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        bit_en,
    input logic        rej_clr,
    input logic        rej_pulse,
    input logic        rx_valid,
    input logic        rej_flag,
    input logic [23:0] rx_word
);
    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r11_valid_from_slot: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(bit_en));

    a_r11_word_held: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_word));

    a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
        rej_pulse |=> rej_flag);

    a_r9_no_word_on_reject: assert property (@(posedge clk) disable iff (rst)
        rej_pulse |=> !rx_valid);

    a_r9_flag_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rej_flag) |-> $past(rej_pulse));

    a_r10_clear_by_request: assert property (@(posedge clk) disable iff (rst)
        $fell(rej_flag) |-> $past(rej_clr));
endmodule

bind fsync_rx fsync_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .rej_clr   (rej_clr),
    .rej_pulse (rej_pulse),
    .rx_valid  (rx_valid),
    .rej_flag  (rej_flag),
    .rx_word   (rx_word)
);

// File: tb/fsync_rx_bench.sv
module fsync_rx_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_en, sdata, fsync;
    logic [1:0]  cfg_wlen;
    logic        cfg_word_fs, cfg_early, cfg_fs_low, cfg_lsb_first, rej_clr;
    logic [23:0] rx_word;
    logic        rx_valid, rej_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [23:0] exp_q[$];
    string       tag_q[$];
    logic [23:0] mon_e;
    string       mon_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsync_rx u_fsync_rx (
        .clk(clk), .rst(rst), .bit_en(bit_en), .sdata(sdata), .fsync(fsync),
        .cfg_wlen(cfg_wlen), .cfg_word_fs(cfg_word_fs), .cfg_early(cfg_early),
        .cfg_fs_low(cfg_fs_low), .cfg_lsb_first(cfg_lsb_first), .rej_clr(rej_clr),
        .rx_word(rx_word), .rx_valid(rx_valid), .rej_flag(rej_flag)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R9/R11 unexpected word: got %h expected none", rx_word);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check(mon_t, rx_word, mon_e);
            end
        end
    end

    function automatic logic [23:0] lmask(input int n);
        return (n >= 24) ? 24'hFFFFFF : ((24'd1 << n) - 24'd1);
    endfunction

    function automatic logic [1:0] wcode(input int n);
        return (n == 8) ? 2'd0 : (n == 12) ? 2'd1 : (n == 16) ? 2'd2 : 2'd3;
    endfunction

    task automatic push(input logic [23:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    // One bit slot: junk values while disabled, then the real values with bit_en
    task automatic slot(input logic f, input logic d, input logic clr = 1'b0);
        @(negedge clk);
        bit_en = 1'b0; rej_clr = 1'b0; fsync = ~f; sdata = ~d;
        @(negedge clk);
        bit_en = 1'b1; fsync = f; sdata = d; rej_clr = clr;
    endtask

    task automatic tick();
        @(negedge clk);
        bit_en = 1'b0; rej_clr = 1'b0;
    endtask

    task automatic idle(input int n, input logic f);
        for (int i = 0; i < n; i++) slot(f, 1'b0);
    endtask

    task automatic set_cfg(input int n, input logic word_fs, input logic early,
                           input logic lsb);
        tick();
        cfg_wlen = wcode(n); cfg_word_fs = word_fs; cfg_early = early;
        cfg_lsb_first = lsb;
    endtask

    function automatic logic pick(input logic [23:0] w, input int n, input logic lsb, input int i);
        return lsb ? w[i] : w[n-1-i];
    endfunction

    // Normal timing frame; rej_at >= 0 injects a second sync edge there
    task automatic send_norm(input logic [23:0] w, input int n, input logic lsb,
                             input logic word_fs, input logic pol_low,
                             input string tag, input int rej_at = -1);
        logic f;
        if (rej_at < 0) push(w & lmask(n), tag);
        if (pol_low) slot(1'b0, 1'b1);
        for (int i = 0; i < n; i++) begin
            if (pol_low)      f = 1'b1;
            else if (word_fs) f = 1'b1;
            else              f = (i == 0) || (i == rej_at);
            slot(f, pick(w, n, lsb, i));
        end
    endtask

    // Early timing frame: sync edge one slot ahead of data
    task automatic send_early(input logic [23:0] w, input int n, input logic lsb,
                              input logic lead, input logic chain, input string tag);
        logic f;
        push(w & lmask(n), tag);
        if (lead) slot(1'b1, 1'b1);
        for (int i = 0; i < n; i++) begin
            f = (i < n-2) ? 1'b1 : ((i == n-2) ? 1'b0 : chain);
            slot(f, pick(w, n, lsb, i));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bit_en = 0; sdata = 0; fsync = 0; rej_clr = 0;
        cfg_wlen = 0; cfg_word_fs = 0; cfg_early = 0; cfg_fs_low = 0; cfg_lsb_first = 0;
        repeat (4) @(negedge clk);
        check("R1 rx_valid in reset", {23'd0, rx_valid}, 24'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rx_valid", {23'd0, rx_valid}, 24'd0);
        check("R1 rej_flag", {23'd0, rej_flag}, 24'd0);
        check("R1 rx_word", rx_word, 24'd0);

        // R2 R4 R5 R6: bit sync, active high, all lengths and both orders
        idle(3, 1'b0);
        set_cfg(8, 0, 0, 0);   send_norm(24'h0000A5, 8, 0, 0, 0, "R2 R4 R5 R6 8b msb");
        idle(2, 1'b0);
        set_cfg(12, 0, 0, 1);  send_norm(24'h0009C3, 12, 1, 0, 0, "R4 R5 12b lsb");
        idle(5, 1'b0);
        set_cfg(16, 0, 0, 0);  send_norm(24'h00BEEF, 16, 0, 0, 0, "R4 R5 16b msb");
        set_cfg(24, 0, 0, 1);  send_norm(24'h5A17C3, 24, 1, 0, 0, "R4 R5 24b lsb");
        // R6: back-to-back normal frames, upper bits masked
        set_cfg(8, 0, 0, 1);
        send_norm(24'hFFFF3C, 8, 1, 0, 0, "R4 R6 back-to-back a");
        send_norm(24'h0000C1, 8, 1, 0, 0, "R6 back-to-back b");
        idle(2, 1'b0);
        check("R6 no reject on adjacent frames", {23'd0, rej_flag}, 24'd0);

        // R6: word-length sync, normal timing
        set_cfg(16, 1, 0, 0);  send_norm(24'h00F00D, 16, 0, 1, 0, "R6 word sync 16b");
        idle(2, 1'b0);

        // R7: early timing, chained frames
        set_cfg(8, 1, 1, 0);
        send_early(24'h00005E, 8, 0, 1, 1, "R7 early a");
        send_early(24'h0000B2, 8, 0, 0, 0, "R7 early b chained");
        idle(3, 1'b0);
        check("R7 no reject on chain", {23'd0, rej_flag}, 24'd0);

        // R8: early ignored with bit sync
        set_cfg(12, 0, 1, 0);  send_norm(24'h000A5C, 12, 0, 0, 0, "R8 early ignored");
        idle(2, 1'b0);

        // R11: long gap with toggling inputs and bit_en low, then idle slots
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); bit_en = 0; fsync = i[0]; sdata = i[1];
        end
        fsync = 0;
        idle(10, 1'b0);
        tick();
        check("R11 gap no flag", {23'd0, rej_flag}, 24'd0);

        // R9: premature edge mid-frame (normal timing)
        set_cfg(16, 0, 0, 0);
        send_norm(24'h001234, 16, 0, 0, 0, "R9 rejected", 5);
        idle(10, 1'b0);
        tick();
        check("R9 flag after mid-frame edge", {23'd0, rej_flag}, 24'd1);
        set_cfg(8, 0, 0, 0);   send_norm(24'h000077, 8, 0, 0, 0, "R9 recovery frame");
        idle(2, 1'b0);

        // R10: write-one-to-clear
        tick(); rej_clr = 1'b1; tick();
        check("R10 cleared", {23'd0, rej_flag}, 24'd0);

        // R9: normal timing, edge on the last bit is rejected
        send_norm(24'h0000AB, 8, 0, 0, 0, "R9 last-bit edge", 7);
        idle(1, 1'b0);
        tick();
        check("R9 flag after last-bit edge", {23'd0, rej_flag}, 24'd1);
        tick(); rej_clr = 1'b1; tick();
        check("R10 cleared again", {23'd0, rej_flag}, 24'd0);

        // R9 R10: early timing, edge before last bit; clear held on the reject slot
        set_cfg(8, 1, 1, 0);
        slot(1'b1, 1'b1);          // edge
        slot(1'b1, 1'b0);          // bit0
        slot(1'b0, 1'b0);          // bit1
        slot(1'b1, 1'b0, 1'b1);    // bit2 with new edge: rejected, clear at same time
        tick();
        check("R10 set wins over clear", {23'd0, rej_flag}, 24'd1);
        idle(8, 1'b0);
        tick(); rej_clr = 1'b1; tick();
        check("R10 cleared after early reject", {23'd0, rej_flag}, 24'd0);

        // R12: settings changed mid-frame do not affect the running frame
        set_cfg(8, 0, 0, 0);
        push(24'h0000C6, "R12 captured settings");
        for (int i = 0; i < 8; i++) begin
            if (i == 3) set_cfg(24, 1, 1, 1);
            slot(i == 0, pick(24'h0000C6, 8, 0, i));
        end
        idle(2, 1'b0);

        // R3: active low, aligns to end of low pulse
        set_cfg(12, 0, 0, 0);
        cfg_fs_low = 1'b1; fsync = 1'b1;
        idle(2, 1'b1);
        send_norm(24'h000E71, 12, 0, 0, 1, "R3 active low 12b");
        idle(2, 1'b1);
        set_cfg(8, 0, 0, 1);
        send_norm(24'h000093, 8, 1, 0, 1, "R3 active low 8b lsb");
        idle(2, 1'b1);
        idle(1, 1'b0);
        tick(); cfg_fs_low = 1'b0;
        idle(3, 1'b0);
        tick();
        check("R3 no reject under low polarity", {23'd0, rej_flag}, 24'd0);

        repeat (4) @(negedge clk);
        check("R11 all expected words seen", 24'(exp_q.size()), 24'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule